// File: doc/BRIEF.md
# I2C Interrupt Vector and Status Unit

This block gathers the event indications produced by an I2C bus engine and exposes them to software through three 16-bit registers: a mask (enable) register, a status register and an interrupt vector register. The bus engine signals seven kinds of event with single-cycle pulses. Each pulse sets a pending flag, which stays set until software removes it. A single interrupt request line is raised while any pending flag is enabled in the mask.

Software services the interrupt by reading the vector register. Each read returns a small code that identifies one pending, enabled event and removes that event in the same access. When nothing enabled remains, the read returns zero, so a service routine can keep reading until it gets zero. The status register also shows two live bus levels (bus busy and receive shift register full). It allows access-ready and stop-detected to be cleared by writing ones. A module enable input holds all latched flags at zero while it is low.

The register port is a plain single-cycle access port with no handshake. A read is accepted in the cycle its strobe is high and its data appears, registered, in the next cycle together with a one-cycle valid flag.

Top module: `i2c_evt_vector_unit`

## Requirements
- R1: After reset all pending flags and the mask are zero, `irq` is low, `rd_valid` is low and `rd_data` is zero.
- R2: The mask register at offset 0x04 holds seven enable bits in bits 6:0 and reads back what was written, with bits 15:7 read as zero. Bit 0 enables arbitration lost, bit 1 no-acknowledge, bit 2 access ready, bit 3 receive ready, bit 4 transmit ready, bit 5 stop detected and bit 6 addressed-as-slave.
- R3: A read of the vector register at offset 0x28 returns the code of a pending enabled event and clears that event's flag. The codes are: arbitration lost 1, no-acknowledge 2, access ready 3, receive ready 4, transmit ready 5, stop detected 6, addressed-as-slave 7.
- R4: When several enabled events are pending, a vector read reports the lowest code, so successive reads return the codes in ascending order.
- R5: A vector read returns 0 when no enabled event is pending. Pending events whose mask bit is clear are neither reported nor removed by it.
- R6: The status register at offset 0x08 shows the latched flags arbitration lost (bit 0), no-acknowledge (bit 1), access ready (bit 2) and stop detected (bit 5). It also shows the live receive-shift-full level at bit 11 and the live bus-busy level at bit 12. All other bits read as zero.
- R7: Writing 1 to status bit 2 or bit 5 clears that flag. Writing 0 there leaves it unchanged. Writes to status bits 0, 1, 11 and 12 have no effect.
- R8: `irq` is high exactly while some pending flag has its mask bit set. It drops in the cycle after the clock edge at which the last such flag is cleared.
- R9: While `mod_en` is low, every latched flag is zero and incoming event pulses are lost. The mask register keeps its value.
- R10: If an event pulse arrives in the same cycle as a clear of that same flag (by vector read or status write), the flag ends up set.
- R11: A read strobed at a clock edge gives `rd_valid` high and the register value (as it was before that edge) on `rd_data` in the following cycle. `rd_data` is zero in cycles without a valid read. Unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_en | input | 1 | Module enable; low holds all flags cleared |
| ev_arb_lost | input | 1 | Pulse: arbitration lost |
| ev_no_ack | input | 1 | Pulse: no-acknowledge received |
| ev_acc_rdy | input | 1 | Pulse: access ready |
| ev_rx_rdy | input | 1 | Pulse: receive data ready |
| ev_tx_rdy | input | 1 | Pulse: transmit data ready |
| ev_stop | input | 1 | Pulse: stop condition detected |
| ev_slv_addr | input | 1 | Pulse: addressed as slave |
| bus_busy | input | 1 | Live level: bus busy |
| rx_shift_full | input | 1 | Live level: receive shift register full |
| reg_addr | input | 6 | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 16 | Write data |
| rd_data | output | 16 | Read data, one cycle after the strobe |
| rd_valid | output | 1 | Read data valid |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check the following. Module enable low empties the flag bank. An event pulse always leaves its flag set, which covers the set-over-clear rule. A clear with no coincident pulse removes the flag. At most one flag is granted to the vector. A read strobe always yields a valid flag one cycle later. A vector read with nothing enabled returns zero. The interrupt line cannot rise without an event or a mask write. The bench's scenarios show the parts that need register traffic: the exact code values and their ascending order, masked events that survive vector reads, the positions of the status bits, the write-one-to-clear behaviour, and the live levels that cannot be cleared. A behavioural model compares `irq`, `rd_valid` and `rd_data` on every clock, and it also does so through a long pseudo-random stretch.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;
  localparam int NUM_EV  = 7;
  localparam int CODE_W  = $clog2(NUM_EV + 1);

  // Flag index; the vector code of each event is its index plus one.
  typedef enum logic [2:0] {
    EV_ARB_LOST = 3'd0,
    EV_NO_ACK   = 3'd1,
    EV_ACC_RDY  = 3'd2,
    EV_RX_RDY   = 3'd3,
    EV_TX_RDY   = 3'd4,
    EV_STOP     = 3'd5,
    EV_SLV_ADDR = 3'd6
  } ev_idx_e;

  // Status word positions of the live levels.
  localparam int ST_RSFULL_BIT = 11;
  localparam int ST_BUSY_BIT   = 12;
endpackage

// File: rtl/i2c_evt_flag_bank.sv
module i2c_evt_flag_bank #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mod_en,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] pend
);
  logic [N-1:0] pend_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pend_q[i] <= 1'b0;
      else if (!mod_en)  pend_q[i] <= 1'b0;
      else if (set_vec[i]) pend_q[i] <= 1'b1;
      else if (clr_vec[i]) pend_q[i] <= 1'b0;
    end

    // R10: a pulse always leaves its flag set, whatever clear coincides
    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mod_en && set_vec[i]) |=> pend_q[i]);
    // R3: a clear without a coincident pulse removes the flag
    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec[i] && !set_vec[i]) |=> !pend_q[i]);
  end

  // R9: module enable low empties the bank
  p_hold_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_en |=> (pend_q == '0));

  assign pend = pend_q;
endmodule

// File: rtl/i2c_evt_vector_pick.sv
module i2c_evt_vector_pick #(
  parameter int N      = 7,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      req,
  output logic [N-1:0]      grant,
  output logic [CODE_W-1:0] code
);
  // Lowest index wins: a running "already taken" chain across the bits.
  logic [N:0] taken;
  assign taken[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant[i]    = req[i] & ~taken[i];
    assign taken[i+1]  = taken[i] | req[i];
  end

  always_comb begin
    code = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (grant[k]) code = CODE_W'(k + 1);
    end
  end

  // R4: never more than one event granted
  p_one_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
endmodule

// File: rtl/i2c_evt_reg_port.sv
module i2c_evt_reg_port
  import i2c_evt_pkg::*;
#(
  parameter int N        = 7,
  parameter int CODE_W   = 3,
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 6,
  parameter logic [ADDR_W-1:0] OFF_MASK   = 6'h04,
  parameter logic [ADDR_W-1:0] OFF_STATUS = 6'h08,
  parameter logic [ADDR_W-1:0] OFF_VECTOR = 6'h28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [N-1:0]      pend,
  input  logic [N-1:0]      grant,
  input  logic [CODE_W-1:0] code,
  input  logic              bus_busy,
  input  logic              rx_shift_full,
  output logic [N-1:0]      mask,
  output logic [N-1:0]      clr_vec,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  logic hit_mask, hit_stat, hit_vec;
  assign hit_mask = (reg_addr == OFF_MASK);
  assign hit_stat = (reg_addr == OFF_STATUS);
  assign hit_vec  = (reg_addr == OFF_VECTOR);

  // Mask register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  mask <= '0;
    else if (reg_wr && hit_mask) mask <= reg_wdata[N-1:0];
  end

  // Clears: vector read takes the granted flag, status write-one-to-clear
  // only touches access ready and stop detected.
  logic [N-1:0] w1c_vec;
  always_comb begin
    w1c_vec = '0;
    if (reg_wr && hit_stat) begin
      w1c_vec[EV_ACC_RDY] = reg_wdata[EV_ACC_RDY];
      w1c_vec[EV_STOP]    = reg_wdata[EV_STOP];
    end
  end
  assign clr_vec = w1c_vec | ((reg_rd && hit_vec) ? grant : '0);

  // Read mux
  logic [DATA_W-1:0] stat_word, mux_word;
  always_comb begin
    stat_word = '0;
    stat_word[EV_ARB_LOST]   = pend[EV_ARB_LOST];
    stat_word[EV_NO_ACK]     = pend[EV_NO_ACK];
    stat_word[EV_ACC_RDY]    = pend[EV_ACC_RDY];
    stat_word[EV_STOP]       = pend[EV_STOP];
    stat_word[ST_RSFULL_BIT] = rx_shift_full;
    stat_word[ST_BUSY_BIT]   = bus_busy;
  end

  always_comb begin
    mux_word = '0;
    if (hit_mask)      mux_word[N-1:0]      = mask;
    else if (hit_stat) mux_word             = stat_word;
    else if (hit_vec)  mux_word[CODE_W-1:0] = code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= reg_rd;
      rd_data  <= reg_rd ? mux_word : '0;
    end
  end

  // R11: every read strobe is answered in the next cycle
  p_rd_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> rd_valid);
  // R5: vector read with nothing granted returns zero
  p_vec_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && hit_vec && (grant == '0)) |=> (rd_data == '0));
endmodule

// File: rtl/i2c_evt_vector_unit.sv
module i2c_evt_vector_unit
  import i2c_evt_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mod_en,
  input  logic              ev_arb_lost,
  input  logic              ev_no_ack,
  input  logic              ev_acc_rdy,
  input  logic              ev_rx_rdy,
  input  logic              ev_tx_rdy,
  input  logic              ev_stop,
  input  logic              ev_slv_addr,
  input  logic              bus_busy,
  input  logic              rx_shift_full,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              irq
);
  logic [NUM_EV-1:0] ev_vec, pend, mask, clr_vec, grant;
  logic [CODE_W-1:0] code;

  always_comb begin
    ev_vec = '0;
    ev_vec[EV_ARB_LOST] = ev_arb_lost;
    ev_vec[EV_NO_ACK]   = ev_no_ack;
    ev_vec[EV_ACC_RDY]  = ev_acc_rdy;
    ev_vec[EV_RX_RDY]   = ev_rx_rdy;
    ev_vec[EV_TX_RDY]   = ev_tx_rdy;
    ev_vec[EV_STOP]     = ev_stop;
    ev_vec[EV_SLV_ADDR] = ev_slv_addr;
  end

  i2c_evt_flag_bank #(.N(NUM_EV)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .mod_en  (mod_en),
    .set_vec (ev_vec),
    .clr_vec (clr_vec),
    .pend    (pend)
  );

  i2c_evt_vector_pick #(.N(NUM_EV), .CODE_W(CODE_W)) u_pick (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (pend & mask),
    .grant (grant),
    .code  (code)
  );

  i2c_evt_reg_port #(
    .N(NUM_EV), .CODE_W(CODE_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_addr      (reg_addr),
    .reg_wr        (reg_wr),
    .reg_rd        (reg_rd),
    .reg_wdata     (reg_wdata),
    .pend          (pend),
    .grant         (grant),
    .code          (code),
    .bus_busy      (bus_busy),
    .rx_shift_full (rx_shift_full),
    .mask          (mask),
    .clr_vec       (clr_vec),
    .rd_data       (rd_data),
    .rd_valid      (rd_valid)
  );

  assign irq = |(pend & mask);

  // R8: the request line cannot rise without an event or a mask write
  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && (ev_vec == '0) && !reg_wr) |=> !irq);
endmodule

// File: tb/i2c_evt_vector_unit_tb.sv
module i2c_evt_vector_unit_tb;
  localparam logic [5:0] A_MASK = 6'h04, A_STAT = 6'h08, A_VEC = 6'h28;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mod_en = 1'b1;
  logic [6:0] ev = '0;
  logic bus_busy = 1'b0, rx_shift_full = 1'b0;
  logic [5:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] rd_data;
  logic rd_valid, irq;

  always #2.5 clk = ~clk;

  i2c_evt_vector_unit u_dut (
    .clk(clk), .rst_n(rst_n), .mod_en(mod_en),
    .ev_arb_lost(ev[0]), .ev_no_ack(ev[1]), .ev_acc_rdy(ev[2]),
    .ev_rx_rdy(ev[3]), .ev_tx_rdy(ev[4]), .ev_stop(ev[5]), .ev_slv_addr(ev[6]),
    .bus_busy(bus_busy), .rx_shift_full(rx_shift_full),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .rd_data(rd_data), .rd_valid(rd_valid), .irq(irq)
  );

  int checks = 0, failures = 0;
  bit done = 0;

  // Behavioural reference model
  bit [6:0] m_pend = '0, m_mask = '0;
  bit [15:0] m_rdata = '0;
  bit m_rv = 0;
  string cur_tag = "R11", m_tag = "R11";

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend = '0; m_mask = '0; m_rdata = '0; m_rv = 0;
    end else begin
      bit [15:0] val;
      bit [6:0] clr;
      bit [6:0] req;
      val = '0; clr = '0;
      req = m_pend & m_mask;
      if (reg_addr == A_MASK) val = {9'd0, m_mask};
      else if (reg_addr == A_STAT)
        val = {3'd0, bus_busy, rx_shift_full, 5'd0, m_pend[5], 2'd0, m_pend[2:0]};
      else if (reg_addr == A_VEC) begin
        for (int k = 6; k >= 0; k--) if (req[k]) val = 16'(k + 1);
      end
      if (reg_rd && reg_addr == A_VEC && val != 0) clr[val-1] = 1'b1;
      if (reg_wr && reg_addr == A_STAT) begin
        clr[2] = clr[2] | reg_wdata[2];
        clr[5] = clr[5] | reg_wdata[5];
      end
      m_rv = reg_rd;
      m_rdata = reg_rd ? val : '0;
      m_tag = cur_tag;
      if (reg_wr && reg_addr == A_MASK) m_mask = reg_wdata[6:0];
      if (!mod_en) m_pend = '0;
      else m_pend = (m_pend & ~clr) | ev;
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R8", "irq", irq, |(m_pend & m_mask));
      chk("R11", "rd_valid", rd_valid, m_rv);
      chk(m_tag, "rd_data", rd_data, m_rdata);
    end
  end

  task automatic rd(logic [5:0] a, string tag);
    cur_tag = tag; reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wr(logic [5:0] a, logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse(logic [6:0] v);
    ev = v;
    @(negedge clk);
    ev = '0;
  endtask

  initial begin
    #500000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    chk("R1", "irq after reset", irq, 0);
    chk("R1", "rd_valid after reset", rd_valid, 0);
    chk("R1", "rd_data after reset", rd_data, 0);
    rd(A_MASK, "R1"); rd(A_STAT, "R1"); rd(A_VEC, "R1");
    @(negedge clk);

    // R2: mask read-back, upper bits ignored
    wr(A_MASK, 16'hFFFF); rd(A_MASK, "R2");
    @(negedge clk);

    // R3 R4: all seven events, codes come out ascending, then R5 zero
    pulse(7'h7F);
    for (int i = 0; i < 8; i++) rd(A_VEC, (i < 7) ? "R4" : "R5");
    @(negedge clk);
    chk("R3", "irq after draining", irq, 0);

    // R5: masked pending events survive vector reads
    wr(A_MASK, 16'h0005);
    pulse(7'b0000110);
    rd(A_VEC, "R3"); rd(A_VEC, "R5"); rd(A_STAT, "R5");
    @(negedge clk);

    // R6 R7: status layout, live levels, write-one-to-clear
    bus_busy = 1'b1; rx_shift_full = 1'b1;
    pulse(7'b0100101);
    rd(A_STAT, "R6");
    wr(A_STAT, 16'h0000); rd(A_STAT, "R7");
    wr(A_STAT, 16'hFFDB); rd(A_STAT, "R7");
    wr(A_STAT, 16'h0024); rd(A_STAT, "R7");
    bus_busy = 1'b0; rd(A_STAT, "R6");
    rx_shift_full = 1'b0;
    rd(A_VEC, "R3"); rd(A_VEC, "R5");
    @(negedge clk);

    // R9: module enable low drops flags and ignores pulses, mask kept
    wr(A_MASK, 16'h007F);
    pulse(7'h7F);
    mod_en = 1'b0;
    @(negedge clk);
    chk("R9", "irq with module disabled", irq, 0);
    pulse(7'h7F);
    rd(A_STAT, "R9"); rd(A_VEC, "R9"); rd(A_MASK, "R9");
    mod_en = 1'b1;
    @(negedge clk);

    // R10: pulse and clear of the same flag in one cycle
    pulse(7'b0000100);
    ev = 7'b0000100; wr(A_STAT, 16'h0004); ev = '0;
    rd(A_STAT, "R10");
    ev = 7'b0000100; rd(A_VEC, "R10"); ev = '0;
    rd(A_VEC, "R10"); rd(A_VEC, "R10");
    @(negedge clk);

    // R11: unmapped offset reads zero
    rd(6'h10, "R11");
    @(negedge clk);

    // Pseudo-random traffic against the model
    for (int n = 0; n < 2000; n++) begin
      int r;
      r = $urandom_range(0, 9);
      ev = ($urandom_range(0, 3) == 0) ? 7'($urandom) : '0;
      bus_busy = 1'($urandom); rx_shift_full = 1'($urandom);
      mod_en = ($urandom_range(0, 40) != 0);
      reg_wr = 1'b0; reg_rd = 1'b0;
      cur_tag = "R3";
      case (r)
        0: begin reg_wr = 1'b1; reg_addr = A_MASK; reg_wdata = 16'($urandom); end
        1: begin reg_wr = 1'b1; reg_addr = A_STAT; reg_wdata = 16'($urandom); end
        2, 3, 4: begin reg_rd = 1'b1; reg_addr = A_VEC; end
        5: begin reg_rd = 1'b1; reg_addr = A_STAT; cur_tag = "R6"; end
        6: begin reg_rd = 1'b1; reg_addr = A_MASK; cur_tag = "R2"; end
        default: ;
      endcase
      @(negedge clk);
    end
    ev = '0; reg_wr = 1'b0; reg_rd = 1'b0; mod_en = 1'b1;
    repeat (3) @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule